// File: doc/BRIEF.md
# I2C Slave Address Recognizer with Alternate Address

This block handles the address phase of an I2C slave. It watches already-synchronized SCL and SDA lines. After a START it shifts in one frame of eight bits on SCL rising edges: seven address bits, most significant first, followed by the read/write bit. It then compares the received address with a primary own address that is always active. It also compares it with an alternate own address when that address is switched on.

On a match the block pulls SDA low for the acknowledge clock. It raises `addressed`, latches the direction bit, and reports through `altSel` whether the alternate address was the one accepted. On a miss it leaves SDA released and ignores all bus activity until the next START. A STOP ends the transaction. A repeated START restarts address capture at any point. The data-byte phase, clock stretching and any buffering belong to other blocks.

The system clock must run several times faster than SCL. Edges and bus conditions are found by comparing each sample with the one taken one clock earlier.

Top module: `i2c_dual_addr_slave`

## Requirements
- R1: After reset, `sdaDriveLow`, `addressed`, `rwBit` and `altSel` are all 0.
- R2: A START is SDA falling while SCL is high. Capture begins there. The next eight SCL rising edges sample SDA in order, giving address bit 6 first, then bits 5 down to 0, and finally the read/write bit (1 = read).
- R3: With `addr2En` = 0, the frame is acknowledged only if the received address equals `ownAddr`.
- R4: With `addr2En` = 1, the frame is acknowledged if the received address equals `ownAddr` or `ownAddr2`.
- R5: On acknowledge, `sdaDriveLow` goes to 1 one clock after the eighth SCL falling edge is sampled. It returns to 0 one clock after the ninth SCL falling edge is sampled.
- R6: `addressed` goes to 1 together with the start of the acknowledge. At that point `rwBit` takes the eighth received bit. Both hold until the next START or STOP, and both are 0 whenever `addressed` is 0.
- R7: `altSel` is 1 only when the acknowledged address matched `ownAddr2` and did not match `ownAddr`. It is 0 after a primary match, after a match where both own addresses are equal, and after no match.
- R8: When nothing matches, SDA is never pulled low and `addressed` stays 0. Bytes that follow on the bus are ignored until the next START, even if they carry a matching address pattern.
- R9: A START seen mid-frame, or after an acknowledge, discards the partial or previous result and begins a fresh address capture.
- R10: A STOP (SDA rising while SCL is high) clears `addressed`, `rwBit` and `altSel` and releases SDA one clock after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized SCL level |
| sdaIn | input | 1 | Synchronized SDA level |
| ownAddr | input | 7 | Primary own address, always active |
| ownAddr2 | input | 7 | Alternate own address |
| addr2En | input | 1 | Enables matching against `ownAddr2` |
| sdaDriveLow | output | 1 | 1 = pull SDA low (acknowledge) |
| addressed | output | 1 | The slave accepted the current frame |
| rwBit | output | 1 | Direction bit of the accepted frame |
| altSel | output | 1 | The accepted address was the alternate one |

## Verification
Every result of this block appears exactly one clock after the SCL or SDA sample that causes it. The acknowledge drive and the three status outputs follow one clock behind the sampled eighth SCL fall. The release follows one clock behind the ninth fall, and the clearing follows one clock behind a START or STOP. The bench changes the bus only on falling clock edges and advances its behavioural model on each rising edge from the same sampled levels. It compares the model with the outputs on the following falling edge, so each comparison lands after the cycle in which the result is due. Directed checks for acknowledge presence, release and status values are taken at fixed half-period points of the master sequence, chosen so that the responsible edge has already been sampled.

// File: rtl/i2c_da_pkg.sv
package i2c_da_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_HOLD,
    ST_SKIP
  } daState_t;

  // control -> datapath
  typedef struct packed {
    logic clrFrame;
    logic shiftEn;
    logic latchHit;
    logic clrHit;
  } daStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic sclRise;
    logic sclFall;
    logic frameFull;
    logic anyHit;
  } daFlags_t;

endpackage

// File: rtl/i2c_da_datapath.sv
module i2c_da_datapath
  import i2c_da_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] ownAddr2,
  input  logic              addr2En,
  input  daStrobe_t         strobe,
  output daFlags_t          flags,
  output logic              addressed,
  output logic              rwBit,
  output logic              altSel
);

  localparam int FRAME_W   = ADDR_W + 1;
  localparam int CNT_W     = $clog2(FRAME_W + 1);
  localparam int NUM_SLOTS = 2;

  logic                 sclQ, sdaQ;
  logic [FRAME_W-1:0]   frameBits;
  logic [CNT_W-1:0]     bitCnt;
  logic [ADDR_W-1:0]    rcvAddr;
  logic [ADDR_W-1:0]    slotAddr [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotEn;
  logic [NUM_SLOTS-1:0] slotHit;
  logic                 altHit;

  // one-sample history of the bus, idle-high after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign rcvAddr = frameBits[FRAME_W-1:1];

  assign slotAddr[0] = ownAddr;
  assign slotAddr[1] = ownAddr2;
  assign slotEn      = {addr2En, 1'b1};

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    assign slotHit[g] = slotEn[g] && (rcvAddr == slotAddr[g]);
  end

  // primary wins when both compare equal
  assign altHit = slotHit[1] & ~slotHit[0];

  always_comb begin
    flags           = '0;
    flags.sclRise   = sclIn & ~sclQ;
    flags.sclFall   = ~sclIn & sclQ;
    flags.startSeen = sclIn & sclQ & sdaQ & ~sdaIn;
    flags.stopSeen  = sclIn & sclQ & ~sdaQ & sdaIn;
    flags.frameFull = (bitCnt == CNT_W'(FRAME_W));
    flags.anyHit    = |slotHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameBits <= '0;
      bitCnt    <= '0;
    end else if (strobe.clrFrame) begin
      frameBits <= '0;
      bitCnt    <= '0;
    end else if (strobe.shiftEn) begin
      frameBits <= {frameBits[FRAME_W-2:0], sdaIn};
      bitCnt    <= bitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addressed <= 1'b0;
      rwBit     <= 1'b0;
      altSel    <= 1'b0;
    end else if (strobe.clrHit) begin
      addressed <= 1'b0;
      rwBit     <= 1'b0;
      altSel    <= 1'b0;
    end else if (strobe.latchHit) begin
      addressed <= 1'b1;
      rwBit     <= frameBits[0];
      altSel    <= altHit;
    end
  end

endmodule

// File: rtl/i2c_da_ctrl.sv
module i2c_da_ctrl
  import i2c_da_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  daFlags_t  flags,
  output daStrobe_t strobe,
  output logic      sdaDriveLow
);

  daState_t state, stateNext;
  logic     driveNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    driveNext = sdaDriveLow;
    if (flags.startSeen) begin
      stateNext       = ST_ADDR;
      strobe.clrFrame = 1'b1;
      strobe.clrHit   = 1'b1;
      driveNext       = 1'b0;
    end else if (flags.stopSeen) begin
      stateNext     = ST_IDLE;
      strobe.clrHit = 1'b1;
      driveNext     = 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (flags.sclRise && !flags.frameFull) begin
            strobe.shiftEn = 1'b1;
          end else if (flags.sclFall && flags.frameFull) begin
            if (flags.anyHit) begin
              stateNext       = ST_ACK;
              strobe.latchHit = 1'b1;
              driveNext       = 1'b1;
            end else begin
              stateNext = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (flags.sclFall) begin
            stateNext = ST_HOLD;
            driveNext = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sdaDriveLow <= 1'b0;
    end else begin
      state       <= stateNext;
      sdaDriveLow <= driveNext;
    end
  end

endmodule

// File: rtl/i2c_dual_addr_slave.sv
module i2c_dual_addr_slave
  import i2c_da_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] ownAddr2,
  input  logic              addr2En,
  output logic              sdaDriveLow,
  output logic              addressed,
  output logic              rwBit,
  output logic              altSel
);

  daStrobe_t strobe;
  daFlags_t  flags;

  i2c_da_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .ownAddr  (ownAddr),
    .ownAddr2 (ownAddr2),
    .addr2En  (addr2En),
    .strobe   (strobe),
    .flags    (flags),
    .addressed(addressed),
    .rwBit    (rwBit),
    .altSel   (altSel)
  );

  i2c_da_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags      (flags),
    .strobe     (strobe),
    .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/i2c_dual_addr_checker.sv
module i2c_dual_addr_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclIn,
  input logic [ADDR_W-1:0] ownAddr,
  input logic [ADDR_W-1:0] ownAddr2,
  input logic              addr2En,
  input logic              sdaDriveLow,
  input logic              addressed,
  input logic              rwBit,
  input logic              altSel
);

  // R5: acknowledge only ever driven for an accepted frame
  a_r5_drive_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    sdaDriveLow |-> addressed);

  // R5: drive starts in the same cycle the hit is recorded
  a_r5_drive_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdaDriveLow) |-> $rose(addressed));

  // R6: hit is recorded only on a sampled SCL fall
  a_r6_hit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> !$past(sclIn));

  // R6: direction bit is zero outside an accepted frame
  a_r6_rw_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rwBit |-> addressed);

  // R7: alternate flag only within an accepted frame
  a_r7_alt_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    altSel |-> addressed);

  // R7: alternate flag requires the second address enabled and distinct
  a_r7_alt_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(altSel) |-> ($past(addr2En) && ($past(ownAddr2) != $past(ownAddr))));

endmodule

bind i2c_dual_addr_slave i2c_dual_addr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclIn      (sclIn),
  .ownAddr    (ownAddr),
  .ownAddr2   (ownAddr2),
  .addr2En    (addr2En),
  .sdaDriveLow(sdaDriveLow),
  .addressed  (addressed),
  .rwBit      (rwBit),
  .altSel     (altSel)
);

// File: tb/i2c_dual_addr_slave_tb.sv
module i2c_dual_addr_slave_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic [6:0] ownAddr = 7'h50;
  logic [6:0] ownAddr2 = 7'h2A;
  logic       addr2En = 1'b0;
  logic       sdaDriveLow, addressed, rwBit, altSel;
  logic       sdaBus;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit running = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign sdaBus = sdaM & ~sdaDriveLow;

  i2c_dual_addr_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclIn(sclM), .sdaIn(sdaBus),
    .ownAddr(ownAddr), .ownAddr2(ownAddr2), .addr2En(addr2En),
    .sdaDriveLow(sdaDriveLow), .addressed(addressed), .rwBit(rwBit), .altSel(altSel)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mMode;        // 0 idle, 1 capture, 2 acking, 3 held, 4 ignoring
  bit  mBits[$];
  bit  mDrv, mAddr, mRw, mAlt;
  bit  pScl = 1, pSda = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      mMode = 0; mBits.delete(); mDrv = 0; mAddr = 0; mRw = 0; mAlt = 0;
      pScl = 1; pSda = 1;
    end else begin
      bit s, d;
      s = sclM;
      d = sdaM & ~mDrv;
      if (s && pScl && pSda && !d) begin
        mMode = 1; mBits.delete(); mDrv = 0; mAddr = 0; mRw = 0; mAlt = 0;
      end else if (s && pScl && !pSda && d) begin
        mMode = 0; mDrv = 0; mAddr = 0; mRw = 0; mAlt = 0;
      end else if (mMode == 1) begin
        if (s && !pScl && mBits.size() < 8) mBits.push_back(d);
        else if (!s && pScl && mBits.size() == 8) begin
          int a;
          bit p, q;
          a = 0;
          for (int k = 0; k < 7; k++) a = a * 2 + int'(mBits[k]);
          p = (a == int'(ownAddr));
          q = addr2En && (a == int'(ownAddr2));
          if (p || q) begin
            mMode = 2; mDrv = 1; mAddr = 1; mRw = mBits[7]; mAlt = q && !p;
          end else mMode = 4;
        end
      end else if (mMode == 2) begin
        if (!s && pScl) begin mMode = 3; mDrv = 0; end
      end
      pScl = s;
      pSda = d;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk("R5", "sdaDriveLow vs model", int'(sdaDriveLow), int'(mDrv));
      chk("R6", "addressed vs model", int'(addressed), int'(mAddr));
      chk("R6", "rwBit vs model", int'(rwBit), int'(mRw));
      chk("R7", "altSel vs model", int'(altSel), int'(mAlt));
    end
  end

  // ---------------- master stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1; tick(2); sclM = 1; tick(2); sdaM = 0; tick(2); sclM = 0; tick(2);
  endtask

  task automatic stopCond();
    sdaM = 0; tick(2); sclM = 1; tick(2); sdaM = 1; tick(2);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(1); sclM = 1; tick(2); sclM = 0; tick(1);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int k = 7; k >= 0; k--) sendBit(b[k]);
    sdaM = 1; tick(1); sclM = 1; tick(1);
    acked = !sdaBus;
    tick(1); sclM = 0; tick(1);
    chk("R5", "SDA released after ninth fall", int'(sdaDriveLow), 0);
  endtask

  function automatic bit expHit(input logic [6:0] a);
    return (a == ownAddr) || (addr2En && a == ownAddr2);
  endfunction

  function automatic bit expAlt(input logic [6:0] a);
    return addr2En && a == ownAddr2 && a != ownAddr;
  endfunction

  task automatic addrFrame(input string req, input logic [6:0] a, input logic rw);
    logic acked;
    bit h;
    h = expHit(a);
    startCond();
    sendByte({a, rw}, acked);
    chk(req, "acknowledge seen", int'(acked), int'(h));
    chk(req, "addressed", int'(addressed), int'(h));
    chk(req, "rwBit", int'(rwBit), int'(h && rw));
    chk(req, "altSel", int'(altSel), int'(expAlt(a)));
  endtask

  initial begin
    logic acked;
    tick(4);
    rst_n = 1;
    tick(2);
    // R1
    chk("R1", "sdaDriveLow after reset", int'(sdaDriveLow), 0);
    chk("R1", "addressed after reset", int'(addressed), 0);
    chk("R1", "rwBit after reset", int'(rwBit), 0);
    chk("R1", "altSel after reset", int'(altSel), 0);
    running = 1;

    // R3, R2: primary match, write
    addrFrame("R3", 7'h50, 1'b0);
    stopCond();
    chk("R10", "addressed cleared by STOP", int'(addressed), 0);
    // R2: bit order, reversed pattern must miss
    addrFrame("R2", 7'h05, 1'b1);
    stopCond();
    // R3: alternate disabled -> miss, R8: following byte ignored
    addrFrame("R3", 7'h2A, 1'b0);
    sendByte({7'h50, 1'b0}, acked);
    chk("R8", "later byte not acknowledged", int'(acked), 0);
    chk("R8", "still not addressed", int'(addressed), 0);
    stopCond();

    addr2En = 1;
    // R4, R7: alternate match, read
    addrFrame("R4", 7'h2A, 1'b1);
    chk("R7", "altSel set for alternate", int'(altSel), 1);
    stopCond();
    chk("R10", "altSel cleared by STOP", int'(altSel), 0);
    chk("R10", "rwBit cleared by STOP", int'(rwBit), 0);
    // R4: primary still works with alternate enabled
    addrFrame("R4", 7'h50, 1'b1);
    stopCond();
    // R8: no match with alternate on
    addrFrame("R8", 7'h11, 1'b0);
    stopCond();
    // R7: equal addresses -> primary
    ownAddr2 = 7'h50;
    tick(2);
    addrFrame("R7", 7'h50, 1'b0);
    chk("R7", "equal addresses give primary", int'(altSel), 0);
    stopCond();
    ownAddr2 = 7'h2A;

    // R9: repeated START mid-frame
    startCond();
    for (int k = 0; k < 4; k++) sendBit(1'b1);
    addrFrame("R9", 7'h50, 1'b0);
    // R9: repeated START after acknowledge selects alternate
    addrFrame("R9", 7'h2A, 1'b1);
    chk("R9", "restart gives alternate", int'(altSel), 1);
    // R9: repeated START after a hit, now missing
    addrFrame("R9", 7'h33, 1'b1);
    stopCond();

    // mixed patterns
    for (int i = 0; i < 24; i++) begin
      logic [6:0] a;
      addr2En = i[0];
      case (i % 4)
        0: a = ownAddr;
        1: a = ownAddr2;
        default: a = 7'($urandom);
      endcase
      addrFrame("R4", a, 1'($urandom));
      if (i % 3 == 0) stopCond();
    end
    stopCond();
    tick(4);

    running = 0;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule